// File: doc/BRIEF.md
# Throttled Transmit Word Link

This block moves 16-bit words from an on-chip ready/valid stream onto an external parallel link. Each word on the link is marked by a one-cycle data-valid strobe. A transmit clock output is derived as the inverse of the block's own send clock. Launch therefore happens on the send clock's rising edge, and the receiving device captures on the transmit clock's rising edge, half a period later.

The receiving device can stop the flow with a not-ready input that is asynchronous to the send clock. That input passes through a synchroniser and a short lag chain, so a fixed number of words (four by default) still leave the block after not-ready rises. Words the host has already handed over while the link is stalled wait in a four-entry skid store. No word is lost or repeated. When not-ready falls, only the synchroniser delay applies before the flow restarts.

For boards that share one cable with other drivers, an output-enable signal lets an external disable input release the data lines. This happens only when a configuration enable is set.

Top module: `txl_link`

## Requirements
- R1: While `rst_n` is low at a rising edge of `send_clk`, `link_dv` is 0, `link_data` is 0 and `host_ready` is 0 after that edge.
- R2: Every word accepted on the host side (`host_valid` and `host_ready` both 1 at a rising edge) appears exactly once on `link_data`, with `link_dv` = 1, in the order of acceptance.
- R3: In any cycle where `link_dv` is 0, `link_data` keeps the value of the last word sent, or 0 if no word has been sent since reset.
- R4: If `dev_not_ready` rises between two edges while words are continuously available, then valid words still appear after each of the next four rising edges, and `link_dv` is 0 after the fifth.
- R5: From the fifth consecutive rising edge at which `dev_not_ready` is sampled high onward, `link_dv` stays 0 for as long as `dev_not_ready` stays high.
- R6: When `dev_not_ready` falls between two edges and a word is held, `link_dv` is 0 after the first two rising edges and 1 after the third.
- R7: The skid store holds up to four words. `host_ready` is 0 exactly when four accepted words are still waiting to be sent.
- R8: `tx_clk` is the logical inverse of `send_clk`: it is 0 while `send_clk` is high and 1 while `send_clk` is low.
- R9: `link_data_oe` is 0 (data lines released) only when both `oe_ctrl_en` and `out_disable` are 1. Otherwise it is 1.
- R10: A word accepted at one rising edge into an empty store appears on the link after the next rising edge. With a continuous stream and no throttle, one word is sent every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| send_clk | input | 1 | Send clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host offers a word |
| host_data | input | 16 | Word offered by the host |
| host_ready | output | 1 | Block can take a word this cycle |
| dev_not_ready | input | 1 | Throttle from the device, asynchronous |
| oe_ctrl_en | input | 1 | Configuration bit allowing external output disable |
| out_disable | input | 1 | External request to release the data lines |
| tx_clk | output | 1 | Transmit clock, inverse of `send_clk` |
| link_data | output | 16 | Word on the link |
| link_dv | output | 1 | Link word valid strobe |
| link_data_oe | output | 1 | Drive enable for the data lines, 1 = drive |

## Verification
The hardest case to reach from the ports is a not-ready edge that arrives while words are in flight in every stage at once. In that situation the synchroniser, the lag chain, the skid store and the output register all hold live data when the throttle takes hold, and again when it releases. The stimulus holds a continuous stream until the store is in steady state, then raises not-ready between edges and counts the words that follow. It then keeps the host pushing until the store fills, and drops not-ready to time the restart. A sweep then repeats throttle windows of several lengths against every four-cycle pattern of host gaps, and a scoreboard confirms that no word is lost or repeated.

// File: rtl/txl_pkg.sv
// Package: txl_pkg
// Shared defaults and helpers for the throttled transmit link.
// Assumes: none; pure constants and a width helper.
package txl_pkg;

    localparam int unsigned TXL_WORD_W = 16;  // link word width
    localparam int unsigned TXL_SKID_D = 4;   // words held while stalled
    localparam int unsigned TXL_SYNC_N = 2;   // synchroniser flops
    localparam int unsigned TXL_LAG_N  = 2;   // extra delay before stop takes effect

    // Pointer width for a store of the given depth (at least one bit).
    function automatic int unsigned txl_ptr_w(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/txl_throttle_sync.sv
// Module: txl_throttle_sync
// Brings the asynchronous not-ready input into the send clock domain and
// produces the stop request for the output stage. Rising not-ready takes
// effect after SYNC_N + LAG_N edges; falling not-ready releases after SYNC_N
// edges, because the stop is the AND of the synchroniser tail and the lag tail.
// Assumes: SYNC_N >= 2, LAG_N >= 1; a not-ready pulse shorter than LAG_N + 1
// cycles at the synchroniser output is filtered out.
module txl_throttle_sync #(
    parameter int unsigned SYNC_N = 2,
    parameter int unsigned LAG_N  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dnr_async,
    output logic hold
);

    logic [SYNC_N-1:0] sync_q;
    logic [LAG_N-1:0]  lag_q;

    // Metastability chain for the asynchronous throttle.
    always_ff @(posedge clk) begin : p_sync_chain
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= dnr_async;
            for (int i = 1; i < int'(SYNC_N); i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // Delay line that sets how many words still go out after a stop.
    always_ff @(posedge clk) begin : p_lag_chain
        if (!rst_n) begin
            lag_q <= '0;
        end else begin
            lag_q[0] <= sync_q[SYNC_N-1];
            for (int i = 1; i < int'(LAG_N); i++) begin
                lag_q[i] <= lag_q[i-1];
            end
        end
    end

    // Stop only while both the fresh and the delayed view agree.
    always_comb begin : p_hold
        hold = sync_q[SYNC_N-1] & lag_q[LAG_N-1];
    end

endmodule

// File: rtl/txl_skid.sv
// Module: txl_skid
// Small circular store between the host stream and the link register.
// Holds the words accepted while the link is stalled.
// Assumes: caller never pushes when full nor pops when empty.
module txl_skid #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         full,
    output logic         empty
);

    localparam int unsigned PW = txl_pkg::txl_ptr_w(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  slot_q [DEPTH];
    logic [PW-1:0] wr_q;
    logic [PW-1:0] rd_q;
    logic [CW-1:0] cnt_q;

    // Wrap-around increment for a pointer.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + PW'(1);
    endfunction

    // Word storage; no reset needed on data.
    always_ff @(posedge clk) begin : p_store
        if (push) begin
            slot_q[wr_q] <= push_data;
        end
    end

    // Pointers and fill level.
    always_ff @(posedge clk) begin : p_ptrs
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Status and head word.
    always_comb begin : p_status
        pop_data = slot_q[rd_q];
        full     = (cnt_q == CW'(DEPTH));
        empty    = (cnt_q == '0);
    end

endmodule

// File: rtl/txl_out_stage.sv
// Module: txl_out_stage
// Launch register for the link: data and valid leave from flops so the
// inverted transmit clock centres them. Data holds when nothing is loaded.
// Assumes: load is a single-cycle request per word.
module txl_out_stage #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic         dv,
    output logic [W-1:0] data
);

    // Register one word per load; keep the last word otherwise.
    always_ff @(posedge clk) begin : p_launch
        if (!rst_n) begin
            dv   <= 1'b0;
            data <= '0;
        end else begin
            dv <= load;
            if (load) begin
                data <= load_data;
            end
        end
    end

endmodule

// File: rtl/txl_link.sv
// Module: txl_link
// Throttled transmit link: host stream -> skid store -> launch register,
// with a synchronised device throttle, an inverted transmit clock and a
// multi-drop output release.
// Assumes: dev_not_ready and out_disable are asynchronous to send_clk;
// host holds host_data stable while host_valid is high and unaccepted.
module txl_link
    import txl_pkg::*;
#(
    parameter int unsigned WORD_W      = TXL_WORD_W,
    parameter int unsigned SKID_DEPTH  = TXL_SKID_D,
    parameter int unsigned SYNC_STAGES = TXL_SYNC_N,
    parameter int unsigned LAG_STAGES  = TXL_LAG_N
) (
    input  logic              send_clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic [WORD_W-1:0] host_data,
    output logic              host_ready,
    input  logic              dev_not_ready,
    input  logic              oe_ctrl_en,
    input  logic              out_disable,
    output logic              tx_clk,
    output logic [WORD_W-1:0] link_data,
    output logic              link_dv,
    output logic              link_data_oe
);

    logic              hold;
    logic              skid_full;
    logic              skid_empty;
    logic [WORD_W-1:0] skid_word;
    logic              push;
    logic              pop;

    // Throttle synchroniser and lag.
    txl_throttle_sync #(
        .SYNC_N (SYNC_STAGES),
        .LAG_N  (LAG_STAGES)
    ) i_sync (
        .clk       (send_clk),
        .rst_n     (rst_n),
        .dnr_async (dev_not_ready),
        .hold      (hold)
    );

    // Skid store for words accepted during a stall.
    txl_skid #(
        .W     (WORD_W),
        .DEPTH (SKID_DEPTH)
    ) i_skid (
        .clk       (send_clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (host_data),
        .pop       (pop),
        .pop_data  (skid_word),
        .full      (skid_full),
        .empty     (skid_empty)
    );

    // Launch register for the link.
    txl_out_stage #(
        .W (WORD_W)
    ) i_out (
        .clk       (send_clk),
        .rst_n     (rst_n),
        .load      (pop),
        .load_data (skid_word),
        .dv        (link_dv),
        .data      (link_data)
    );

    // Host handshake and transfer decisions.
    always_comb begin : p_flow
        host_ready = rst_n & ~skid_full;
        push       = host_valid & host_ready;
        pop        = ~skid_empty & ~hold;
    end

    // Transmit clock and data-line release.
    always_comb begin : p_pins
        tx_clk       = ~send_clk;
        link_data_oe = ~(oe_ctrl_en & out_disable);
    end

endmodule

// File: rtl/txl_link_chk.sv
// Module: txl_link_chk
// Assertion checker for txl_link, bound to every instance below.
// Tracks accepted and sent word counts and the run length of the throttle
// so that stall, order and fill properties can be checked at the ports.
// Assumes: attached through the bind at the end of this file.
module txl_link_chk #(
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned DEPTH   = 4,
    parameter int unsigned LATENCY = 4
) (
    input logic              send_clk,
    input logic              rst_n,
    input logic              host_valid,
    input logic              host_ready,
    input logic              dev_not_ready,
    input logic              link_dv,
    input logic [WORD_W-1:0] link_data
);

    localparam int unsigned RUN_W = $clog2(LATENCY + 2);

    logic [15:0]      acc_cnt;
    logic [15:0]      emi_cnt;
    logic [15:0]      in_skid;
    logic [RUN_W-1:0] run_q;

    // Word counters and saturating run length of the throttle.
    always_ff @(posedge send_clk) begin : p_track
        if (!rst_n) begin
            acc_cnt <= '0;
            emi_cnt <= '0;
            run_q   <= '0;
        end else begin
            if (host_valid && host_ready) acc_cnt <= acc_cnt + 16'd1;
            if (link_dv)                  emi_cnt <= emi_cnt + 16'd1;
            if (!dev_not_ready)                   run_q <= '0;
            else if (run_q <= RUN_W'(LATENCY))    run_q <= run_q + RUN_W'(1);
        end
    end

    // Words still waiting in the store after the previous edge.
    assign in_skid = acc_cnt - emi_cnt - 16'(link_dv);

    p_dv_backed_r2: assert property (@(posedge send_clk) disable iff (!rst_n)
        link_dv |-> (acc_cnt != emi_cnt));

    p_hold_data_r3: assert property (@(posedge send_clk) disable iff (!rst_n)
        !link_dv |-> $stable(link_data));

    p_stop_r5: assert property (@(posedge send_clk) disable iff (!rst_n)
        (run_q > RUN_W'(LATENCY)) |-> !link_dv);

    p_no_overflow_r7: assert property (@(posedge send_clk) disable iff (!rst_n)
        in_skid <= 16'(DEPTH));

    p_full_stall_r7: assert property (@(posedge send_clk) disable iff (!rst_n)
        !host_ready |-> (in_skid == 16'(DEPTH)));

endmodule

bind txl_link txl_link_chk #(
    .WORD_W  (WORD_W),
    .DEPTH   (SKID_DEPTH),
    .LATENCY (SYNC_STAGES + LAG_STAGES)
) i_txl_link_chk (
    .send_clk      (send_clk),
    .rst_n         (rst_n),
    .host_valid    (host_valid),
    .host_ready    (host_ready),
    .dev_not_ready (dev_not_ready),
    .link_dv       (link_dv),
    .link_data     (link_data)
);

// File: tb/test_txl_link.sv
// Bench for txl_link: directed timing checks around the throttle plus a
// sweep of host gap patterns against throttle windows, scored arithmetically.
module test_txl_link;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int LAT        = 4;

    logic        send_clk      = 1'b0;
    logic        rst_n         = 1'b0;
    logic        host_valid    = 1'b0;
    logic [15:0] host_data     = '0;
    logic        dev_not_ready = 1'b0;
    logic        oe_ctrl_en    = 1'b0;
    logic        out_disable   = 1'b0;
    logic        host_ready;
    logic        tx_clk;
    logic [15:0] link_data;
    logic        link_dv;
    logic        link_data_oe;

    int          checks   = 0;
    int          fails    = 0;
    bit          done     = 1'b0;
    logic [15:0] sb_mem [1024];
    int          sb_wr    = 0;
    int          sb_rd    = 0;
    int          seq      = 0;
    int          dnr_run  = 0;
    logic [15:0] last_data = '0;

    txl_link i_txl_link (
        .send_clk      (send_clk),
        .rst_n         (rst_n),
        .host_valid    (host_valid),
        .host_data     (host_data),
        .host_ready    (host_ready),
        .dev_not_ready (dev_not_ready),
        .oe_ctrl_en    (oe_ctrl_en),
        .out_disable   (out_disable),
        .tx_clk        (tx_clk),
        .link_data     (link_data),
        .link_dv       (link_dv),
        .link_data_oe  (link_data_oe)
    );

    always #(CLK_PERIOD/2) send_clk = ~send_clk;

    function automatic logic [15:0] word_of(input int n);
        return 16'(n * 40503 + 4660);
    endfunction

    task automatic expect_eq(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // One clock: record the push, pass the edge, score the outputs at negedge.
    task automatic cycle();
        bit acc;
        acc = host_valid && host_ready;
        if (acc) begin
            sb_mem[sb_wr % 1024] = host_data;
            sb_wr++;
        end
        if (dev_not_ready) dnr_run++; else dnr_run = 0;
        @(negedge send_clk);
        if (link_dv) begin
            expect_eq("R2", "word order", 32'(link_data), 32'(sb_mem[sb_rd % 1024]));
            sb_rd++;
            last_data = link_data;
        end else begin
            expect_eq("R3", "data hold", 32'(link_data), 32'(last_data));
        end
        if (dnr_run > LAT) expect_eq("R5", "dv while stopped", 32'(link_dv), 32'd0);
        if (!host_ready) expect_eq("R7", "store fill at stall", 32'(sb_wr - sb_rd), 32'(DEPTH));
        if (acc) seq++;
        host_data = word_of(seq);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge send_clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : stimulus
        host_data = word_of(0);
        // R1: reset state
        repeat (3) begin
            @(negedge send_clk);
            expect_eq("R1", "dv in reset", 32'(link_dv), 32'd0);
            expect_eq("R1", "data in reset", 32'(link_data), 32'd0);
            expect_eq("R1", "ready in reset", 32'(host_ready), 32'd0);
        end
        rst_n = 1'b1;
        #1 expect_eq("R7", "ready when empty", 32'(host_ready), 32'd1);

        // R10: latency of one edge, then a word per cycle
        host_valid = 1'b1;
        cycle();
        expect_eq("R10", "no dv on push edge", 32'(link_dv), 32'd0);
        cycle();
        expect_eq("R10", "dv one edge later", 32'(link_dv), 32'd1);
        repeat (20) begin
            cycle();
            expect_eq("R10", "full rate", 32'(link_dv), 32'd1);
        end

        // R4: exactly four words after not-ready rises; R7 store fills
        dev_not_ready = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            cycle();
            expect_eq("R4", "dv after stop", 32'(link_dv), (k <= LAT) ? 32'd1 : 32'd0);
        end
        expect_eq("R7", "ready low when full", 32'(host_ready), 32'd0);
        expect_eq("R7", "four words held", 32'(sb_wr - sb_rd), 32'(DEPTH));

        // R6: restart on the third edge after release
        dev_not_ready = 1'b0;
        for (int k = 1; k <= 10; k++) begin
            cycle();
            expect_eq("R6", "dv after release", 32'(link_dv), (k >= 3) ? 32'd1 : 32'd0);
        end

        // R3: idle host, link drains then holds
        host_valid = 1'b0;
        repeat (8) cycle();
        expect_eq("R3", "idle dv", 32'(link_dv), 32'd0);
        expect_eq("R2", "all words sent", 32'(sb_wr - sb_rd), 32'd0);

        // Sweep: host gap patterns against throttle windows (R2, R3, R5, R7)
        for (int pat = 1; pat < 16; pat++) begin
            for (int hl = 2; hl <= 11; hl += 3) begin
                for (int k = 0; k < 30; k++) begin
                    host_valid    = pat[k % 4];
                    dev_not_ready = (k >= 6) && (k < 6 + hl);
                    cycle();
                end
                host_valid    = 1'b0;
                dev_not_ready = 1'b0;
                repeat (10) cycle();
                expect_eq("R2", "sweep drained", 32'(sb_wr - sb_rd), 32'd0);
            end
        end

        // R8: transmit clock is the inverse of the send clock
        for (int i = 0; i < 4; i++) begin
            @(posedge send_clk);
            #1 expect_eq("R8", "tx_clk high phase", 32'(tx_clk), 32'd0);
            @(negedge send_clk);
            #1 expect_eq("R8", "tx_clk low phase", 32'(tx_clk), 32'd1);
        end

        // R9: data lines released only with both controls set
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                oe_ctrl_en  = a[0];
                out_disable = b[0];
                #1 expect_eq("R9", "output enable", 32'(link_data_oe),
                             (a == 1 && b == 1) ? 32'd0 : 32'd1);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule